// File: doc/BRIEF.md
# Element-Counted Vector Loop Controller

This block sequences a vector loop whose length is given as a number of data elements instead of a number of passes. A start command loads the total element count and an element-size code. The element size sets how many lanes one vector holds. In each pass the block drives a lane-enable mask to the datapath. When the datapath reports that the pass is complete, the block subtracts one vector's worth of lanes from the remaining count.

In the final pass only the lanes that still hold real elements are enabled. Because of this, a count that is not a multiple of the lane count needs no separate scalar clean-up loop. When the last pass completes, the block raises a one-cycle finished pulse and drops its busy flag. A start with a zero count produces the pulse at once and runs no pass.

Top module: `tp_loop_ctrl`

## Requirements
- R1: After reset `busy_o` is 0, `lane_en_o` is all zeros and `done_o` is 0.
- R2: The element-size code selects the lanes per pass: code 0 gives 16 lanes, code 1 gives 8, code 2 gives 4 and code 3 gives 2. Lane i maps to bit i of `lane_en_o`.
- R3: A `go_i` sampled while idle with a nonzero `elems_i` sets `busy_o` from the next cycle on, and the first pass's mask appears in that same cycle.
- R4: Each cycle with `pass_done_i` high while busy lowers the remaining count by the lanes per pass. The loop stays busy while elements remain.
- R5: While busy, `lane_en_o` enables the lowest min(remaining, lanes) bits as a contiguous group, and every other bit is 0.
- R6: With code 2 and a count of 10, the loop runs 3 passes with masks 0xF, 0xF and 0x3.
- R7: A `go_i` with a count of 0 pulses `done_o` in the next cycle and never raises `busy_o`.
- R8: `done_o` is high for exactly one cycle, in the cycle after the last pass's `pass_done_i`, and `busy_o` is low in that same cycle.
- R9: `go_i` while busy, and `pass_done_i` while idle, have no effect.
- R10: `lane_en_o` is all zeros whenever `busy_o` is low.
- R11: When the count is an exact multiple of the lanes, the last pass has a full mask and no empty pass follows it. The remaining count stops at zero and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Start command |
| elems_i | input | CNT_W | Total element count, sampled on start |
| esize_i | input | 2 | Element-size code, sampled on start |
| pass_done_i | input | 1 | Datapath has finished the current pass |
| lane_en_o | output | 16 | Lane-enable mask for the current pass |
| busy_o | output | 1 | Loop in progress |
| done_o | output | 1 | One-cycle pulse after the final pass |

## Verification
The bench runs counts just below, at and just above a multiple of the lane count for every element size. A design that gets the boundary wrong would either issue an extra all-zero pass or a full mask in a short last pass. Zero-count starts are aimed at a design that would enter a busy state with nothing to do or forget the finished pulse. A restart issued mid-loop checks that the mask and the remaining count are not reloaded. A done handshake while idle checks that it cannot create a spurious finished pulse.

// File: rtl/tp_loop_ctrl.sv
module tp_loop_ctrl #(
  parameter int CNT_W = 16,
  parameter int LANES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [CNT_W-1:0] elems_i,
  input  logic [1:0]       esize_i,
  input  logic             pass_done_i,
  output logic [LANES-1:0] lane_en_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int LW = $clog2(LANES) + 1;

  logic [CNT_W-1:0] rem_q;
  logic [LW-1:0]    lanes_q;
  logic             busy_q, done_q;

  logic [CNT_W-1:0] lanes_ext;
  logic             last_pass;
  logic [LW-1:0]    take;
  logic [LANES:0]   mask_wide;

  assign lanes_ext = CNT_W'(lanes_q);
  assign last_pass = rem_q <= lanes_ext;
  assign take      = last_pass ? LW'(rem_q) : lanes_q;
  assign mask_wide = ((LANES+1)'(1) << take) - (LANES+1)'(1);

  assign lane_en_o = busy_q ? mask_wide[LANES-1:0] : '0;
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q   <= '0;
      lanes_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          if (elems_i == '0) begin
            done_q <= 1'b1;
          end else begin
            busy_q  <= 1'b1;
            rem_q   <= elems_i;
            lanes_q <= LW'(LANES) >> esize_i;
          end
        end
      end else if (pass_done_i) begin
        if (last_pass) begin
          rem_q  <= '0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          rem_q <= rem_q - lanes_ext;
        end
      end
    end
  end
endmodule

// File: rtl/tp_loop_ctrl_chk.sv
module tp_loop_ctrl_chk #(
  parameter int CNT_W = 16,
  parameter int LANES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go_i,
  input logic [CNT_W-1:0] elems_i,
  input logic             pass_done_i,
  input logic [LANES-1:0] lane_en_o,
  input logic             busy_o,
  input logic             done_o
);
  p_idle_mask_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> lane_en_o == '0);

  p_mask_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (lane_en_o != '0) &&
      ((({1'b0, lane_en_o} + (LANES+1)'(1)) & {1'b0, lane_en_o}) == '0));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o && pass_done_i) ||
               $past(!busy_o && go_i && elems_i == '0));

  p_go_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && go_i && !pass_done_i |=> busy_o && $stable(lane_en_o));

  p_zero_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && go_i && elems_i == '0 |=> done_o && !busy_o);
endmodule

bind tp_loop_ctrl tp_loop_ctrl_chk #(.CNT_W(CNT_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_i(go_i), .elems_i(elems_i),
  .pass_done_i(pass_done_i), .lane_en_o(lane_en_o),
  .busy_o(busy_o), .done_o(done_o)
);

// File: tb/tp_loop_ctrl_test.sv
module tp_loop_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [15:0] elems = '0;
  logic [1:0]  esize = '0;
  logic        pdone = 1'b0;
  logic [15:0] lane_en;
  logic        busy, done;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  tp_loop_ctrl uut (
    .clk(clk), .rst_n(rst_n), .go_i(go), .elems_i(elems), .esize_i(esize),
    .pass_done_i(pdone), .lane_en_o(lane_en), .busy_o(busy), .done_o(done)
  );

  // {size code, count, passes, lanes in last pass}
  localparam logic [31:0] VEC [10] = '{
    {2'd2, 14'd10, 8'd3, 8'd2},
    {2'd0, 14'd16, 8'd1, 8'd16},
    {2'd0, 14'd17, 8'd2, 8'd1},
    {2'd1, 14'd8,  8'd1, 8'd8},
    {2'd1, 14'd21, 8'd3, 8'd5},
    {2'd3, 14'd5,  8'd3, 8'd1},
    {2'd3, 14'd4,  8'd2, 8'd2},
    {2'd2, 14'd1,  8'd1, 8'd1},
    {2'd0, 14'd40, 8'd3, 8'd8},
    {2'd2, 14'd12, 8'd3, 8'd4}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] want(input int rem, input int lanes);
    int t = rem < lanes ? rem : lanes;
    logic [16:0] m = (17'd1 << t) - 17'd1;
    return m[15:0];
  endfunction

  task automatic run(input logic [1:0] es, input int cnt, output int passes, output int lastl);
    int rem = cnt;
    int lanes = 16 >> es;
    passes = 0;
    lastl = 0;
    @(negedge clk); go = 1'b1; esize = es; elems = cnt[15:0];
    @(negedge clk); go = 1'b0;
    if (cnt == 0) begin
      chk(done === 1'b1, "R7 done", done, 1);
      chk(busy === 1'b0, "R7 busy", busy, 0);
      @(negedge clk);
      chk(done === 1'b0, "R8 one-cycle", done, 0);
      return;
    end
    chk(busy === 1'b1, "R3 busy", busy, 1);
    for (int k = 0; k < 64; k++) begin
      chk(lane_en === want(rem, lanes), "R5/R2 mask", lane_en, want(rem, lanes));
      lastl = $countones(lane_en);
      passes++;
      pdone = 1'b1;
      @(negedge clk); pdone = 1'b0;
      rem = rem > lanes ? rem - lanes : 0;
      if (rem == 0) begin
        chk(done === 1'b1 && busy === 1'b0, "R8 finish", {done, busy}, 2);
        @(negedge clk);
        chk(done === 1'b0, "R8 one-cycle", done, 0);
        break;
      end
      chk(busy === 1'b1 && done === 1'b0, "R4 continue", {done, busy}, 1);
    end
  endtask

  initial begin
    int p, l;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && lane_en === '0 && done === 1'b0, "R1 reset", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      run(VEC[i][31:30], int'(VEC[i][29:16]), p, l);
      chk(p == int'(VEC[i][15:8]), "R4/R11 passes", p, VEC[i][15:8]);
      chk(l == int'(VEC[i][7:0]), "R6/R11 last lanes", l, VEC[i][7:0]);
    end

    run(2'd2, 0, p, l);

    // pass_done while idle
    @(negedge clk); pdone = 1'b1;
    @(negedge clk); pdone = 1'b0;
    chk(busy === 1'b0 && done === 1'b0 && lane_en === '0, "R9 idle done ignored", {busy, done}, 0);
    chk(lane_en === '0, "R10 idle mask", lane_en, 0);

    // restart while busy
    @(negedge clk); go = 1'b1; esize = 2'd2; elems = 16'd10;
    @(negedge clk); go = 1'b0; pdone = 1'b1;
    @(negedge clk); pdone = 1'b0; go = 1'b1; esize = 2'd0; elems = 16'd3;
    @(negedge clk); go = 1'b0;
    chk(busy === 1'b1 && lane_en === 16'h000F, "R9 go ignored", lane_en, 16'h000F);
    pdone = 1'b1;
    @(negedge clk); pdone = 1'b0;
    chk(lane_en === 16'h0003, "R6 tail after restart", lane_en, 3);
    pdone = 1'b1;
    @(negedge clk); pdone = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, "R8 finish after restart", {done, busy}, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule